// File: doc/BRIEF.md
# Checksummed Six-Byte Frame Transmitter

This block takes a five-byte payload from a host, adds a sixth byte that protects the frame, and passes the six bytes in order to a byte-wide UART transmitter. The host puts the payload on a parallel bus and pulses a start strobe. The block copies the payload into registers at that moment and computes the check byte from the copy. It then offers the bytes one at a time on a valid/ready byte stream.

The ready input reflects the UART transmitter's "holding register empty" status. A byte counts as sent on any cycle in which valid and ready are both high. While a frame is being sent, `busy` stays high and any further start request is ignored. One cycle after the sixth byte is taken, `done` pulses for one cycle and the block is idle again. The check byte is the XOR of the five payload bytes, seeded with a fixed constant.

Top module: `csum_frame_tx`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `done` are all low.
- R2: When `start` is high while the block is idle, the payload is accepted. On the next cycle `busy` and `tx_valid` are high and `tx_data` shows payload byte 0, which is `payload[7:0]`. Payload byte k sits at bits `[8k+7:8k]`.
- R3: The bytes go out in the order payload byte 0, 1, 2, 3, 4, then the check byte.
- R4: The check byte equals 8'h5A XOR byte0 XOR byte1 XOR byte2 XOR byte3 XOR byte4.
- R5: The block moves to the next byte only on a cycle with `tx_valid` and `uart_ready` both high. While `uart_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R6: Each accepted start sends exactly six bytes. After the sixth byte is taken, `tx_valid` goes low and stays low until the next accepted start.
- R7: `done` is high for exactly one cycle, the cycle after the sixth byte is taken. In that cycle `busy` is already low.
- R8: A `start` request that arrives while `busy` is high is ignored. It causes no second frame and does not change the bytes of the frame in progress.
- R9: The payload is captured only when a start is accepted. Later changes on `payload` do not affect the frame being sent.
- R10: A start held high through the `done` cycle is accepted at the next clock edge. A second frame then follows with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request from the host |
| payload | input | 40 | Five payload bytes, byte k at bits [8k+7:8k] |
| uart_ready | input | 1 | The UART transmitter can take a byte |
| tx_valid | output | 1 | A frame byte is being offered |
| tx_data | output | 8 | The offered frame byte |
| busy | output | 1 | A frame is in flight |
| done | output | 1 | One-cycle pulse after the last byte is taken |

## Verification
An accepted start shows up one clock edge later: at that point `busy`, `tx_valid` and byte 0 on `tx_data` are all present. A handshake at one edge puts the next byte on `tx_data` by the following edge. A handshake on the sixth byte lowers `busy` and raises `done` at that same next edge, and `done` falls at the edge after that. The bench drives its inputs on falling edges and reads state half a cycle later. It records handshakes on rising edges, using the values from before the edge. Each check therefore lands on the exact cycle in which the result is due, and ready patterns with stalls show whether data holds still while `uart_ready` is low.

// File: rtl/csum_frame_pkg.sv
package csum_frame_pkg;

    localparam int unsigned DEF_DATA_W    = 8;
    localparam int unsigned DEF_PAYLOAD_N = 5;
    localparam logic [7:0]  DEF_SEED      = 8'h5A;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

endpackage

// File: rtl/csum_fold.sv
module csum_fold #(
    parameter int unsigned          DATA_W    = 8,
    parameter int unsigned          PAYLOAD_N = 5,
    parameter logic [DATA_W-1:0]    SEED      = 8'h5A
) (
    input  logic [PAYLOAD_N-1:0][DATA_W-1:0] pay,
    output logic [DATA_W-1:0]                sum
);

    logic [DATA_W-1:0] stage [PAYLOAD_N+1];

    assign stage[0] = SEED;

    for (genvar g = 0; g < PAYLOAD_N; g++) begin : g_fold
        assign stage[g+1] = stage[g] ^ pay[g];
    end

    assign sum = stage[PAYLOAD_N];

endmodule

// File: rtl/frame_byte_sel.sv
module frame_byte_sel #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PAYLOAD_N = 5,
    localparam int unsigned FRAME_N  = PAYLOAD_N + 1,
    localparam int unsigned IDX_W    = $clog2(FRAME_N + 1)
) (
    input  logic [PAYLOAD_N-1:0][DATA_W-1:0] pay,
    input  logic [DATA_W-1:0]                csum,
    input  logic [IDX_W-1:0]                 idx,
    output logic [DATA_W-1:0]                byte_out
);

    logic [DATA_W-1:0] slot [FRAME_N];

    for (genvar g = 0; g < FRAME_N; g++) begin : g_slot
        if (g < PAYLOAD_N) begin : g_pay
            assign slot[g] = pay[g];
        end else begin : g_sum
            assign slot[g] = csum;
        end
    end

    always_comb begin
        byte_out = '0;
        for (int i = 0; i < FRAME_N; i++) begin
            if (idx == IDX_W'(i)) begin
                byte_out = slot[i];
            end
        end
    end

endmodule

// File: rtl/csum_frame_tx.sv
module csum_frame_tx
    import csum_frame_pkg::*;
#(
    parameter int unsigned       DATA_W    = DEF_DATA_W,
    parameter int unsigned       PAYLOAD_N = DEF_PAYLOAD_N,
    parameter logic [DATA_W-1:0] SEED      = DATA_W'(DEF_SEED)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [PAYLOAD_N*DATA_W-1:0] payload,
    input  logic                        uart_ready,
    output logic                        tx_valid,
    output logic [DATA_W-1:0]           tx_data,
    output logic                        busy,
    output logic                        done
);

    localparam int unsigned      FRAME_N = PAYLOAD_N + 1;
    localparam int unsigned      IDX_W   = $clog2(FRAME_N + 1);
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(FRAME_N);

    typedef struct packed {
        phase_e                          phase;
        logic [IDX_W-1:0]                idx;
        logic [DATA_W-1:0]               csum;
        logic [PAYLOAD_N-1:0][DATA_W-1:0] pay;
        logic                            done;
    } state_t;

    state_t state_d, state_q;

    logic [PAYLOAD_N-1:0][DATA_W-1:0] pay_in;
    logic [DATA_W-1:0]                csum_new;
    logic [DATA_W-1:0]                cur_byte;
    logic                             fire;
    logic [IDX_W-1:0]                 idx_inc;

    assign pay_in = payload;

    csum_fold #(
        .DATA_W    (DATA_W),
        .PAYLOAD_N (PAYLOAD_N),
        .SEED      (SEED)
    ) i_fold (
        .pay (pay_in),
        .sum (csum_new)
    );

    frame_byte_sel #(
        .DATA_W    (DATA_W),
        .PAYLOAD_N (PAYLOAD_N)
    ) i_sel (
        .pay      (state_q.pay),
        .csum     (state_q.csum),
        .idx      (state_q.idx),
        .byte_out (cur_byte)
    );

    assign tx_valid = (state_q.phase == PH_SEND) && (state_q.idx < END_IDX);
    assign tx_data  = cur_byte;
    assign busy     = (state_q.phase == PH_SEND);
    assign done     = state_q.done;
    assign fire     = tx_valid && uart_ready;
    assign idx_inc  = state_q.idx + IDX_W'(1);

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        unique case (state_q.phase)
            PH_IDLE: begin
                if (start) begin
                    state_d.phase = PH_SEND;
                    state_d.idx   = '0;
                    state_d.pay   = pay_in;
                    state_d.csum  = csum_new;
                end
            end
            PH_SEND: begin
                if (fire) begin
                    state_d.idx = idx_inc;
                    if (idx_inc == END_IDX) begin
                        state_d.phase = PH_IDLE;
                        state_d.done  = 1'b1;
                    end
                end
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/csum_frame_tx_chk.sv
module csum_frame_tx_chk #(
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       PAYLOAD_N = 5,
    parameter logic [DATA_W-1:0] SEED      = 8'h5A
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic [PAYLOAD_N*DATA_W-1:0] payload,
    input logic                        uart_ready,
    input logic                        tx_valid,
    input logic [DATA_W-1:0]           tx_data,
    input logic                        busy,
    input logic                        done
);

    localparam int unsigned      FRAME_N = PAYLOAD_N + 1;
    localparam int unsigned      CNT_W   = $clog2(FRAME_N + 1);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME_N - 1);

    logic              hs;
    logic [CNT_W-1:0]  seen_q;
    logic [DATA_W-1:0] acc_q;

    assign hs = tx_valid && uart_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            acc_q  <= SEED;
        end else if (hs) begin
            if (seen_q == LAST_C) begin
                seen_q <= '0;
                acc_q  <= SEED;
            end else begin
                seen_q <= seen_q + CNT_W'(1);
                acc_q  <= acc_q ^ tx_data;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !busy && !tx_valid && !done) else $error("reset state"); // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> (busy && tx_valid)) else $error("start not taken"); // R2
    AST_CHECK_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (hs && seen_q == LAST_C) |-> (tx_data == acc_q)) else $error("check byte"); // R4
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && !uart_ready) |=> (tx_valid && $stable(tx_data))) else $error("stall hold"); // R5
    AST_NO_IDLE_VALID: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !tx_valid) else $error("valid while idle"); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) (hs && seen_q == LAST_C) |=> (done && !busy)) else $error("done missing"); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done too long"); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !(hs && seen_q == LAST_C)) |=> busy) else $error("busy dropped"); // R8

endmodule

bind csum_frame_tx csum_frame_tx_chk #(
    .DATA_W    (DATA_W),
    .PAYLOAD_N (PAYLOAD_N),
    .SEED      (SEED)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .payload    (payload),
    .uart_ready (uart_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_csum_frame_tx.sv
`timescale 1ns/1ps
module test_csum_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [39:0] payload = '0;
    logic        uart_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int ncap = 0;
    int ndone = 0;
    int stall_err = 0;
    logic [7:0] cap [0:255];
    logic       stall_prev = 1'b0;
    logic [7:0] data_prev = '0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    csum_frame_tx i_csum_frame_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .payload(payload),
        .uart_ready(uart_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (stall_prev && !(tx_valid && tx_data == data_prev)) stall_err++;
            stall_prev <= tx_valid && !uart_ready;
            data_prev  <= tx_data;
            if (tx_valid && uart_ready) begin
                cap[ncap[7:0]] <= tx_data;
                ncap++;
            end
            if (done) ndone++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [39:0] p, input int k);
        logic [7:0] s;
        if (k < 5) return p[8*k +: 8];
        s = 8'h5A;
        for (int i = 0; i < 5; i++) s = s ^ p[8*i +: 8];
        return s;
    endfunction

    task automatic check_frame(input logic [39:0] p, input int base, input string tag);
        for (int k = 0; k < 6; k++) begin
            chk(cap[base + k] == exp_byte(p, k), tag, cap[base + k], exp_byte(p, k));
        end
    endtask

    // Run ready pattern until done is seen; mode 0 always ready, N: ready once every N+1 cycles.
    task automatic run_until_done(input int mode);
        int cyc = 0;
        while (!done && cyc < 500) begin
            uart_ready = (mode == 0) ? 1'b1 : ((cyc % (mode + 1)) == 0);
            @(negedge clk);
            cyc++;
        end
        uart_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy && !tx_valid && !done, "R1 reset state", {busy, tx_valid, done}, 0);
    endtask

    task automatic t_frame(input logic [39:0] p, input int mode);
        int base = ncap;
        int d0 = ndone;
        start = 1'b1; payload = p; uart_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy && tx_valid && tx_data == p[7:0], "R2 first byte", tx_data, p[7:0]);
        run_until_done(mode);
        chk(done && !busy, "R7 done with busy low", {done, busy}, 2);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        chk(ndone == d0 + 1, "R7 done count", ndone - d0, 1);
        repeat (4) @(negedge clk);
        chk(ncap - base == 6 && !tx_valid, "R6 six bytes", ncap - base, 6);
        check_frame(p, base, "R3 R4 frame bytes");
        chk(stall_err == 0, "R5 hold during stall", stall_err, 0);
    endtask

    task automatic t_busy_start(input logic [39:0] p1, input logic [39:0] p2);
        int base = ncap;
        int d0 = ndone;
        start = 1'b1; payload = p1; uart_ready = 1'b0;
        @(negedge clk);
        payload = p2;
        repeat (3) @(negedge clk);
        chk(busy && tx_data == p1[7:0], "R9 byte 0 after payload change", tx_data, p1[7:0]);
        start = 1'b0;
        run_until_done(1);
        repeat (10) @(negedge clk);
        chk(ndone == d0 + 1 && !busy, "R8 no second frame", ndone - d0, 1);
        chk(ncap - base == 6, "R8 byte count", ncap - base, 6);
        check_frame(p1, base, "R9 latched payload");
    endtask

    task automatic t_back_to_back(input logic [39:0] p);
        int base = ncap;
        start = 1'b1; payload = p;
        @(negedge clk);
        run_until_done(0);
        chk(!busy, "R10 idle at done", busy, 0);
        @(negedge clk);
        chk(busy && tx_valid && tx_data == p[7:0], "R10 restart at once", busy, 1);
        start = 1'b0;
        run_until_done(0);
        repeat (3) @(negedge clk);
        chk(ncap - base == 12, "R10 two frames", ncap - base, 12);
        check_frame(p, base, "R10 frame one");
        check_frame(p, base + 6, "R10 frame two");
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(40'h44_33_22_11_00, 0);
        t_frame(40'hFF_A5_5A_0F_F0, 1);
        t_frame(40'h00_00_00_00_00, 2);
        t_frame(40'h80_7E_01_C3_5A, 3);
        t_busy_start(40'h12_34_56_78_9A, 40'hDE_AD_BE_EF_01);
        t_back_to_back(40'h0A_0B_0C_0D_0E);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule